// File: doc/BRIEF.md
# Level-1 latency pipeline and derandomizer

This block serves one readout channel. On every bunch crossing it stores an 18-bit sample, made of 16 data bits and 2 error bits, in a circular history memory. The memory holds 200 crossings, which gives the Level-1 trigger time to decide. The `latency` input sets how far back the capture window begins. When a Level-1 accept arrives, the block copies ten consecutive buckets from the history into a free slot of a 44-slot derandomizing bank. It copies one bucket per crossing. While the copy runs, it also builds a running data sum and the error summary for that event.

A readout port empties the bank in arrival order. Each event leaves as a record of 14 sixteen-bit words, moved by a valid/ready handshake. The block also applies the trigger rules. It rejects an accept that arrives while a copy is still running, an accept beyond the per-orbit limit, and an accept that comes while the bank is full. Each rejection is reported by a one-cycle flag, and a level output shows when the bank has no free slot.

Top module: `l1_latency_derand`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the block. After reset, `out_valid`, `full` and `l1a_reject` are low, the crossing number restarts at 0, and the event numbering starts again.
- R2: For an accept at crossing t with latency L (1 to 199, held constant for ten crossings), data word j (j = 0..9) of the record equals the 16 data bits of the sample presented at crossing t−L+j.
- R3: A record is exactly 14 words in this order: event ID, header, the ten data words, the sum, the trailer. `out_last` is high with the trailer and with no other word.
- R4: In the header, bits 11:0 hold the crossing number of the accept. That number counts from 0 at the first crossing after reset and wraps after 3563. Bit 15 is set if error bit 1 (`samp_err[1]`) is set in any of the ten buckets. Bit 14 does the same for error bit 0. Bits 13:12 are zero.
- R5: The sum word is the sum, modulo 2^16, of the ten data fields of the event.
- R6: In the trailer, bit 15 is set if any error bit is set in any bucket. Bits 7:0 hold the history address of bucket 0, which is (t−L) mod 200, where t counts crossings since reset. All other bits are zero.
- R7: The event ID is the number of accepted triggers since reset, modulo 2^16; the first event after reset carries ID 1. Rejected triggers do not advance it.
- R8: An `l1a` in any of the nine crossings after an accepted one is rejected.
- R9: No more than 22 triggers are accepted within one orbit of 3564 crossings. The count restarts at crossing 0.
- R10: `full` is high while 44 events are held, counting one still being captured. An `l1a` while `full` is high is rejected.
- R11: `l1a_reject` is high for exactly the one cycle after a rejected `l1a`. It is never high after an accepted `l1a` or after a cycle with no `l1a`.
- R12: Events leave in acceptance order. An event becomes valid in the crossing after its tenth bucket is written. The output word advances only when `out_valid` and `rd_ready` are both high, and `out_word` holds steady otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_data | input | 16 | Data field of this crossing's sample |
| samp_err | input | 2 | Error bits of this crossing's sample |
| latency | input | 8 | Trigger latency in crossings (1 to 199) |
| l1a | input | 1 | Level-1 accept request for this crossing |
| rd_ready | input | 1 | Readout side takes the current word |
| out_valid | output | 1 | A record word is available |
| out_word | output | 16 | Current record word |
| out_last | output | 1 | Current word is the record trailer |
| full | output | 1 | All derandomizing slots are in use |
| l1a_reject | output | 1 | The previous cycle's accept was refused |

## Verification
Two functions can act on the same clock edge: capturing a new accept, which takes a slot, and popping the trailer of the oldest event, which frees one. The slot count and `full` must come out right when both happen together. The bench provokes this by running dense triggers against a randomly stalling reader. It also lets the bank fill up and then drains it, so that accepts land on the very edges where trailers are consumed. Each crossing it compares `full`, `out_valid`, the word stream and the reject flag against a queue model, which gives a precise verdict on every shared edge.

// File: rtl/l1pipe_pkg.sv
package l1pipe_pkg;

   // Words around the data buckets: ID and header before, sum and trailer after.
   localparam int HDR_WORDS = 2;
   localparam int TRL_WORDS = 2;

   function automatic int rec_words(input int win);
      return win + HDR_WORDS + TRL_WORDS;
   endfunction

endpackage

// File: rtl/l1pipe_history.sv
// Circular sample history written every crossing, read at a fixed offset behind.
module l1pipe_history #(
   parameter int SW    = 18,
   parameter int DEPTH = 200,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [SW-1:0] din,
   input  logic [AW-1:0] lat,
   output logic [SW-1:0] dout,
   output logic [AW-1:0] rd_addr
);

   logic [SW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr;

   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) wr_ptr <= '0;
            else     wr_ptr <= wr_ptr + 1'b1;
         end
         assign rd_addr = wr_ptr - lat;
      end else begin : g_mod
         always_ff @(posedge clk) begin
            if (rst)                            wr_ptr <= '0;
            else if (wr_ptr == AW'(DEPTH - 1))  wr_ptr <= '0;
            else                                wr_ptr <= wr_ptr + 1'b1;
         end
         always_comb begin
            if (wr_ptr >= lat) rd_addr = wr_ptr - lat;
            else rd_addr = AW'((AW+1)'(DEPTH) + {1'b0, wr_ptr} - {1'b0, lat});
         end
      end
   endgenerate

   always_ff @(posedge clk) mem[wr_ptr] <= din;

   assign dout = mem[rd_addr];

endmodule

// File: rtl/l1pipe_rule.sv
// Crossing counter within the orbit and per-orbit accept budget.
module l1pipe_rule #(
   parameter int ORBIT_LEN = 3564,
   parameter int MAX_ACC   = 22,
   parameter int BCN_W     = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   output logic [BCN_W-1:0] bcn,
   output logic             quota_ok
);

   localparam int QW = $clog2(MAX_ACC + 1);

   logic [QW-1:0] n_acc;
   logic          orbit_end;

   assign orbit_end = (bcn == BCN_W'(ORBIT_LEN - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         bcn   <= '0;
         n_acc <= '0;
      end else begin
         bcn   <= orbit_end ? '0 : bcn + 1'b1;
         n_acc <= orbit_end ? '0 : n_acc + QW'(accept);
      end
   end

   assign quota_ok = (n_acc < QW'(MAX_ACC));

endmodule

// File: rtl/l1pipe_derand.sv
// Slot bank: captures a window one bucket per crossing, replays it as a record.
module l1pipe_derand
   import l1pipe_pkg::*;
#(
   parameter int DW    = 16,
   parameter int EW    = 2,
   parameter int WIN   = 10,
   parameter int NBUF  = 44,
   parameter int AW    = 8,
   parameter int BCN_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [DW+EW-1:0] sample,
   input  logic [AW-1:0]    start_addr,
   input  logic [BCN_W-1:0] bcn_in,
   output logic             busy,
   output logic             full,
   input  logic             rd_ready,
   output logic             out_valid,
   output logic [DW-1:0]    out_word,
   output logic             out_last
);

   localparam int SW   = DW + EW;
   localparam int SLW  = $clog2(NBUF);
   localparam int CNTW = $clog2(NBUF + 1);
   localparam int IW   = $clog2(WIN);
   localparam int RECW = rec_words(WIN);
   localparam int RW   = $clog2(RECW);
   localparam int BW   = $clog2(NBUF * WIN);

   logic [SW-1:0]    bank    [NBUF*WIN];
   logic [DW-1:0]    s_id    [NBUF];
   logic [BCN_W-1:0] s_bcn   [NBUF];
   logic [AW-1:0]    s_addr  [NBUF];
   logic [DW-1:0]    s_sum   [NBUF];
   logic [EW-1:0]    s_state [NBUF];

   logic [DW-1:0]   evid;
   logic [SLW-1:0]  wslot, rslot, cap_slot, tgt_slot;
   logic [CNTW-1:0] used;
   logic            capturing, pop;
   logic [IW-1:0]   cap_idx, tgt_idx;
   logic [RW-1:0]   rd_idx;
   logic [BW-1:0]   wbw, rbw;
   logic [DW-1:0]   s_data;
   logic [EW-1:0]   s_err;

   assign s_data = sample[DW-1:0];
   assign s_err  = sample[SW-1:DW];

   always_comb begin
      tgt_slot = start ? wslot : cap_slot;
      tgt_idx  = start ? '0 : cap_idx;
      wbw      = BW'(int'(tgt_slot) * WIN + int'(tgt_idx));
   end

   // storage, no reset
   always_ff @(posedge clk) begin
      if (start || capturing) bank[wbw] <= sample;
      if (start) begin
         s_id[wslot]    <= evid + 1'b1;
         s_bcn[wslot]   <= bcn_in;
         s_addr[wslot]  <= start_addr;
         s_sum[wslot]   <= s_data;
         s_state[wslot] <= s_err;
      end else if (capturing) begin
         s_sum[cap_slot]   <= s_sum[cap_slot] + s_data;
         s_state[cap_slot] <= s_state[cap_slot] | s_err;
      end
   end

   assign pop = out_valid && rd_ready && out_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         evid      <= '0;
         wslot     <= '0;
         rslot     <= '0;
         cap_slot  <= '0;
         used      <= '0;
         capturing <= 1'b0;
         cap_idx   <= '0;
         rd_idx    <= '0;
      end else begin
         used <= used + CNTW'(start) - CNTW'(pop);
         if (start) begin
            evid      <= evid + 1'b1;
            cap_slot  <= wslot;
            cap_idx   <= IW'(1);
            capturing <= 1'b1;
            wslot     <= (wslot == SLW'(NBUF - 1)) ? '0 : wslot + 1'b1;
         end else if (capturing) begin
            cap_idx <= cap_idx + 1'b1;
            if (cap_idx == IW'(WIN - 1)) capturing <= 1'b0;
         end
         if (out_valid && rd_ready) begin
            if (out_last) begin
               rd_idx <= '0;
               rslot  <= (rslot == SLW'(NBUF - 1)) ? '0 : rslot + 1'b1;
            end else begin
               rd_idx <= rd_idx + 1'b1;
            end
         end
      end
   end

   assign busy      = capturing;
   assign full      = (used == CNTW'(NBUF));
   assign out_valid = (used > CNTW'(capturing));
   assign out_last  = (rd_idx == RW'(RECW - 1));

   always_comb begin
      out_word = '0;
      rbw      = BW'(int'(rslot) * WIN + int'(rd_idx) - HDR_WORDS);
      if (rd_idx == RW'(0)) begin
         out_word = s_id[rslot];
      end else if (rd_idx == RW'(1)) begin
         out_word[DW-1 -: EW]  = s_state[rslot];
         out_word[BCN_W-1:0]   = s_bcn[rslot];
      end else if (rd_idx < RW'(WIN + HDR_WORDS)) begin
         out_word = bank[rbw][DW-1:0];
      end else if (rd_idx == RW'(WIN + HDR_WORDS)) begin
         out_word = s_sum[rslot];
      end else begin
         out_word[DW-1]   = |s_state[rslot];
         out_word[AW-1:0] = s_addr[rslot];
      end
   end

endmodule

// File: rtl/l1_latency_derand.sv
module l1_latency_derand #(
   parameter int DATA_W     = 16,
   parameter int ERR_W      = 2,
   parameter int HIST_DEPTH = 200,
   parameter int WIN        = 10,
   parameter int NBUF       = 44,
   parameter int ORBIT_LEN  = 3564,
   parameter int MAX_ACC    = 22,
   parameter int BCN_W      = 12,
   localparam int AW        = $clog2(HIST_DEPTH),
   localparam int SW        = DATA_W + ERR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] samp_data,
   input  logic [ERR_W-1:0]  samp_err,
   input  logic [AW-1:0]     latency,
   input  logic              l1a,
   input  logic              rd_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_word,
   output logic              out_last,
   output logic              full,
   output logic              l1a_reject
);

   generate
      if (BCN_W + ERR_W > DATA_W) begin : g_bad_hdr
         $error("header cannot hold crossing number and data state");
      end
      if (AW >= DATA_W) begin : g_bad_trl
         $error("trailer cannot hold history address");
      end
      if (ORBIT_LEN > (1 << BCN_W)) begin : g_bad_orbit
         $error("orbit length exceeds crossing counter");
      end
      if (WIN < 2 || NBUF < 2) begin : g_bad_bank
         $error("window and bank need at least two entries");
      end
   endgenerate

   logic             accept, busy, full_i, quota_ok;
   logic [BCN_W-1:0] bcn;
   logic [AW-1:0]    hist_addr;
   logic [SW-1:0]    delayed;

   assign accept = l1a & ~busy & ~full_i & quota_ok;
   assign full   = full_i;

   always_ff @(posedge clk) begin
      if (rst) l1a_reject <= 1'b0;
      else     l1a_reject <= l1a & ~accept;
   end

   l1pipe_history #(.SW(SW), .DEPTH(HIST_DEPTH), .AW(AW)) u_hist (
      .clk     (clk),
      .rst     (rst),
      .din     ({samp_err, samp_data}),
      .lat     (latency),
      .dout    (delayed),
      .rd_addr (hist_addr)
   );

   l1pipe_rule #(.ORBIT_LEN(ORBIT_LEN), .MAX_ACC(MAX_ACC), .BCN_W(BCN_W)) u_rule (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .bcn      (bcn),
      .quota_ok (quota_ok)
   );

   l1pipe_derand #(.DW(DATA_W), .EW(ERR_W), .WIN(WIN), .NBUF(NBUF), .AW(AW), .BCN_W(BCN_W)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .start      (accept),
      .sample     (delayed),
      .start_addr (hist_addr),
      .bcn_in     (bcn),
      .busy       (busy),
      .full       (full_i),
      .rd_ready   (rd_ready),
      .out_valid  (out_valid),
      .out_word   (out_word),
      .out_last   (out_last)
   );

endmodule

// File: rtl/l1_latency_derand_chk.sv
module l1_latency_derand_chk #(
   parameter int WIN       = 10,
   parameter int ORBIT_LEN = 3564,
   parameter int MAX_ACC   = 22,
   parameter int BCN_W     = 12,
   parameter int DW        = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             l1a,
   input logic             accept,
   input logic [BCN_W-1:0] bcn,
   input logic             rd_ready,
   input logic             out_valid,
   input logic [DW-1:0]    out_word,
   input logic             out_last,
   input logic             full,
   input logic             l1a_reject
);

   localparam int GW = $clog2(WIN + 1);
   localparam int QW = $clog2(MAX_ACC + 1) + 1;

   logic [GW-1:0] gap;
   logic [QW-1:0] orb_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap     <= GW'(WIN);
         orb_cnt <= '0;
      end else begin
         if (accept)               gap <= '0;
         else if (gap != GW'(WIN)) gap <= gap + 1'b1;
         if (bcn == BCN_W'(ORBIT_LEN - 1)) orb_cnt <= '0;
         else                              orb_cnt <= orb_cnt + QW'(accept);
      end
   end

   // R8
   spacing_chk: assert property (@(posedge clk) disable iff (rst)
      accept |-> gap >= GW'(WIN - 1));

   // R9
   quota_chk: assert property (@(posedge clk) disable iff (rst)
      accept |-> orb_cnt < QW'(MAX_ACC));

   // R10
   full_valid_chk: assert property (@(posedge clk) disable iff (rst)
      full |-> out_valid);

   // R10
   full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
      (full && l1a) |=> l1a_reject);

   // R11
   reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
      l1a_reject |-> $past(l1a));

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !rd_ready) |=> (out_valid && $stable(out_word)));

   // R3
   last_chk: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);

endmodule

bind l1_latency_derand l1_latency_derand_chk #(
   .WIN(WIN), .ORBIT_LEN(ORBIT_LEN), .MAX_ACC(MAX_ACC), .BCN_W(BCN_W), .DW(DATA_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .l1a        (l1a),
   .accept     (accept),
   .bcn        (bcn),
   .rd_ready   (rd_ready),
   .out_valid  (out_valid),
   .out_word   (out_word),
   .out_last   (out_last),
   .full       (full),
   .l1a_reject (l1a_reject)
);

// File: tb/l1_latency_derand_tb.sv
module l1_latency_derand_tb;

   localparam int WIN   = 10;
   localparam int NBUF  = 44;
   localparam int OL    = 3564;
   localparam int MAXA  = 22;
   localparam int DEPTH = 200;
   localparam int RECW  = WIN + 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst = 1'b1;
   logic [15:0] samp_data = '0;
   logic [1:0]  samp_err = '0;
   logic [7:0]  latency = 8'd50;
   logic        l1a = 1'b0, rd_ready = 1'b0;
   logic        out_valid, out_last, full, l1a_reject;
   logic [15:0] out_word;

   l1_latency_derand u_dut (
      .clk(clk), .rst(rst), .samp_data(samp_data), .samp_err(samp_err),
      .latency(latency), .l1a(l1a), .rd_ready(rd_ready),
      .out_valid(out_valid), .out_word(out_word), .out_last(out_last),
      .full(full), .l1a_reject(l1a_reject)
   );

   typedef struct {
      int g;
      int e;
      int lat;
      int id;
      int bcn;
   } ev_t;

   ev_t         q[$];
   logic [17:0] slog [0:16383];
   int  checks = 0, errors = 0;
   int  g = 0, ne = 0, widx = 0, idc = 0, ocnt = 0, last_acc = -100;
   bit  rej_exp = 1'b0, exp_valid = 1'b0, done = 1'b0;
   string rej_why = "R11";

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, ne);
      end
   endtask

   function automatic logic [15:0] exp_word(input ev_t ev, input int k);
      logic [15:0] s  = '0;
      logic [1:0]  st = '0;
      logic [15:0] w  = '0;
      for (int j = 0; j < WIN; j++) begin
         logic [17:0] smp;
         smp = slog[(ev.g - ev.lat + j) & 16383];
         s  = s + smp[15:0];
         st = st | smp[17:16];
      end
      if (k == 0) w = 16'(ev.id);
      else if (k == 1) begin
         w[15:14] = st;
         w[11:0]  = 12'(ev.bcn);
      end else if (k < WIN + 2) w = slog[(ev.g - ev.lat + k - 2) & 16383][15:0];
      else if (k == WIN + 2) w = s;
      else begin
         w[15]  = |st;
         w[7:0] = 8'((ev.e - ev.lat) % DEPTH);
      end
      return w;
   endfunction

   function automatic string word_req(input int k);
      if (k == 0) return "R7 event id";
      if (k == 1) return "R4 header";
      if (k < WIN + 2) return "R2 data bucket";
      if (k == WIN + 2) return "R5 sum";
      return "R6 trailer";
   endfunction

   task automatic compare();
      exp_valid = (q.size() > 0) && (ne >= q[0].e + WIN);
      chk(out_valid == exp_valid, "R12 out_valid", out_valid, exp_valid);
      if (exp_valid && out_valid) begin
         logic [15:0] w;
         w = exp_word(q[0], widx);
         chk(out_word == w, word_req(widx), out_word, w);
         chk(out_last == (widx == RECW - 1), "R3 out_last", out_last, widx == RECW - 1);
      end
      chk(full == (q.size() == NBUF), "R10 full", full, q.size() == NBUF);
      chk(l1a_reject == rej_exp, rej_why, l1a_reject, rej_exp);
   endtask

   // one crossing: check, drive, advance model, wait for next falling edge
   task automatic cycle(input int lpct, input int rpct, input int epct);
      bit busy, fl, quota, acc, fire;
      compare();
      samp_data = 16'($urandom);
      samp_err  = ($urandom_range(99) < epct) ? 2'($urandom_range(3, 1)) : 2'b00;
      l1a       = (ne >= DEPTH) && ($urandom_range(99) < lpct);
      rd_ready  = ($urandom_range(99) < rpct);
      slog[g & 16383] = {samp_err, samp_data};
      fire  = exp_valid && rd_ready;
      busy  = (ne - last_acc) < WIN;
      fl    = (q.size() == NBUF);
      quota = (ocnt < MAXA);
      acc   = l1a && !busy && !fl && quota;
      rej_exp = l1a && !acc;
      rej_why = busy ? "R8 spacing reject" : fl ? "R10 full reject" :
                !quota ? "R9 orbit quota reject" : "R11 reject flag";
      if (acc) begin
         ev_t ev;
         idc = (idc + 1) & 16'hFFFF;
         ev.g = g; ev.e = ne; ev.lat = int'(latency); ev.id = idc; ev.bcn = ne % OL;
         q.push_back(ev);
         last_acc = ne;
      end
      if (fire) begin
         if (widx == RECW - 1) begin
            void'(q.pop_front());
            widx = 0;
         end else widx++;
      end
      ocnt = ((ne % OL) == OL - 1) ? 0 : ocnt + int'(acc);
      ne++;
      g++;
      @(negedge clk);
   endtask

   task automatic run(input int n, input int lpct, input int rpct, input int epct);
      for (int i = 0; i < n; i++) cycle(lpct, rpct, epct);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      l1a = 1'b0;
      rd_ready = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         g++;
      end
      q.delete();
      widx = 0; idc = 0; ocnt = 0; last_acc = -100; ne = 0;
      rej_exp = 1'b0; rej_why = "R11 reject flag";
      rst = 1'b0;
      // R1: state right after reset
      chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      chk(full == 1'b0, "R1 full after reset", full, 0);
      chk(l1a_reject == 1'b0, "R1 reject after reset", l1a_reject, 0);
   endtask

   task automatic set_lat(input int v);
      run(12, 0, 100, 10);
      latency = 8'(v);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      run(400, 5, 100, 10);          // R2 sparse triggers, free reader
      run(300, 60, 70, 20);          // R8 dense triggers, R12 stalling reader
      set_lat(1);
      run(300, 8, 60, 15);
      set_lat(199);
      run(300, 8, 60, 15);
      set_lat(37);
      run(8000, 100, 0, 10);         // R9 orbit quota, R10 fill to full
      run(1500, 30, 50, 10);         // drain while accepts land on pops
      do_reset();                    // R1, R7 numbering restarts
      run(400, 5, 100, 10);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule